// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock synchronous memory for FPGA or ASIC use. Read data is registered twice: once at the address stage and once at the output stage, so a read issued on one edge shows up after the next edge. Writes go to the array on the edge that samples them. The data word is made of four byte lanes. A write either fills every lane or, under a separate byte-write qualifier, fills only the lanes picked by per-lane enables.

An access starts when either of two address strobes is low on an edge with all three selects asserted. That edge loads the burst base address. On later edges with both strobes high, the burst-step input moves the low two address bits through a four-beat sequence, or holds them in place. The sequence is linear or interleaved, chosen by a static input. A strobe on an edge where the selects are not all asserted ends the access.

An output-enable input gates the data output without a clock. A sleep input stops the block and leaves it deselected. The data output is modelled as a data bus plus a drive flag. The bus reads zero while the flag is low.

Top module: `burst_sram`

## Requirements
- R1: While reset is high and on the cycle after reset is released, `rdata_drv` is 0. No access is active until a strobe loads an address.
- R2: A read loaded on edge N (a strobe low with all selects asserted, and no write) makes `rdata_drv` 1 and puts the word at that address on `rdata` after edge N+1, provided `out_en_n` is 0 and `sleep` is 0.
- R3: When `wr_all_n` is 0 on a write-capable cycle, all four lanes are written, whatever `wr_byte_n` and `lane_wr_n` hold.
- R4: When `wr_all_n` is 1 and `wr_byte_n` is 0, each bit `lane_wr_n[i]` that is 0 writes lane i (`wdata[8i+7:8i]`). Several lanes may be written at once. If all `lane_wr_n` bits are 1, or if `wr_byte_n` is 1, the cycle is a read.
- R5: A load through `strobe_proc_n` (low) is always a read, and its write inputs have no effect. A load through `strobe_ctl_n` alone, and every continue cycle, obey the write inputs.
- R6: A continue cycle (both strobes high, access active, `burst_step_n` 0) advances the beat k = 1, 2, 3, 0, ... With `seq_linear` = 1 the low two address bits are (base + k) mod 4. With `seq_linear` = 0 they are base XOR k. The upper bits stay fixed and the sequence wraps back to the base.
- R7: A continue cycle with `burst_step_n` = 1 accesses the same address again, so the beat does not move.
- R8: The selects are active-low `sel_a_n`, active-low `sel_b_n` and active-high `sel_c`. A strobe on an edge where they are not all asserted deselects the block. `rdata_drv` is then 0 after the following edge, and continue cycles do nothing until the next load.
- R9: `out_en_n` = 1 forces `rdata_drv` to 0 in the same cycle, with no clock needed, and has no effect on the pipeline.
- R10: A write cycle on edge N gives `rdata_drv` = 0 after edge N+1.
- R11: `sleep` = 1 forces `rdata_drv` to 0 at once. While it is high, every other input is ignored and nothing is written. After sleep the block is deselected.
- R12: A read of an address written on the previous cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Address, sampled on load cycles |
| strobe_ctl_n | input | 1 | Address strobe, write-capable (active low) |
| strobe_proc_n | input | 1 | Address strobe, read-only load (active low) |
| burst_step_n | input | 1 | Advance the burst on continue cycles (active low) |
| sel_a_n | input | 1 | Select, active low |
| sel_b_n | input | 1 | Select, active low |
| sel_c | input | 1 | Select, active high |
| wr_all_n | input | 1 | Write all lanes (active low) |
| wr_byte_n | input | 1 | Byte-write qualifier (active low) |
| lane_wr_n | input | LANES | Per-lane write enables (active low) |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Output enable, asynchronous (active low) |
| sleep | input | 1 | Sleep |
| seq_linear | input | 1 | 1 = linear burst, 0 = interleaved |
| rdata | output | LANES*LANE_W | Read data (zero while not driven) |
| rdata_drv | output | 1 | Output driven flag |

## Verification
Every address is first filled with full-word writes. Directed phases then cover each write-control pattern: global write with the lane enables set to other values, single lanes, paired lanes, all lanes disabled, and the byte qualifier off. Lane-level read-back shows whether the global/byte priority is honoured. Bursts from every base offset, in both orders, show whether the linear and interleaved sequences and their wrap are correct. Suspended steps show whether the hold keeps the address. A random mix of strobes, selects, steps, writes, output enable and short sleeps shows whether the pipeline depth, the deselect timing and the write-then-read order are right across arbitrary interleavings.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_DESEL = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             strobe_ctl_n,
  input  logic             strobe_proc_n,
  input  logic             burst_step_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_kind_e        kind,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] lane_we,
  output logic             rd_go
);
  logic             active_q;
  logic             selected;
  logic             strobed;
  logic             wr_ok;
  logic [LANES-1:0] we_dec;

  assign selected = !sel_a_n && !sel_b_n && sel_c;
  assign strobed  = !strobe_ctl_n || !strobe_proc_n;

  always_comb begin
    kind = CYC_IDLE;
    if (!rst && !sleep) begin
      if (strobed)       kind = selected ? CYC_LOAD : CYC_DESEL;
      else if (active_q) kind = CYC_CONT;
    end
  end

  // global write outranks the byte qualifier and lane enables
  always_comb begin
    if (!wr_all_n)       we_dec = '1;
    else if (!wr_byte_n) we_dec = ~lane_wr_n;
    else                 we_dec = '0;
  end

  assign load    = (kind == CYC_LOAD);
  assign step    = (kind == CYC_CONT) && !burst_step_n;
  assign wr_ok   = (kind == CYC_CONT) || (load && strobe_proc_n);
  assign lane_we = wr_ok ? we_dec : '0;
  assign rd_go   = (load || kind == CYC_CONT) && (lane_we == '0);

  always_ff @(posedge clk) begin
    if (rst || sleep)            active_q <= 1'b0;
    else if (kind == CYC_LOAD)   active_q <= 1'b1;
    else if (kind == CYC_DESEL)  active_q <= 1'b0;
  end
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seq_linear,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] beat_q;
  logic [BB-1:0] beat_nxt;
  logic [AW-1:0] addr_cur;
  logic [AW-1:0] addr_nxt;

  function automatic logic [BB-1:0] beat_ofs(input logic [BB-1:0] b,
                                             input logic [BB-1:0] k,
                                             input logic lin);
    return lin ? (b + k) : (b ^ k);
  endfunction

  assign beat_nxt = beat_q + 1'b1;
  assign addr_cur = {base_q[AW-1:BB], beat_ofs(base_q[BB-1:0], beat_q, seq_linear)};
  assign addr_nxt = {base_q[AW-1:BB], beat_ofs(base_q[BB-1:0], beat_nxt, seq_linear)};

  always_comb begin
    if (load)      eff_addr = load_addr;
    else if (step) eff_addr = addr_nxt;
    else           eff_addr = addr_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= load_addr;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_nxt;
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[raddr];
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int BURST  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int BB    = $clog2(BURST),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             strobe_ctl_n,
  input  logic             strobe_proc_n,
  input  logic             burst_step_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [DW-1:0]    wdata,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic             seq_linear,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drv
);
  cyc_kind_e        kind;
  logic             load;
  logic             step;
  logic [LANES-1:0] lane_we;
  logic             rd_go;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    rd_addr_q;
  logic             rd_vld_q;
  logic             drv_q;
  logic [DW-1:0]    arr_q;

  burst_sram_ctl #(.LANES(LANES)) ctl_i (
    .clk(clk), .rst(rst), .sleep(sleep),
    .strobe_ctl_n(strobe_ctl_n), .strobe_proc_n(strobe_proc_n),
    .burst_step_n(burst_step_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .kind(kind), .load(load), .step(step), .lane_we(lane_we), .rd_go(rd_go)
  );

  burst_sram_seq #(.AW(AW), .BB(BB)) seq_i (
    .clk(clk), .rst(rst), .seq_linear(seq_linear),
    .load(load), .step(step), .load_addr(addr), .eff_addr(eff_addr)
  );

  burst_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
    .clk(clk), .we(lane_we), .waddr(eff_addr), .wdata(wdata),
    .raddr(rd_addr_q), .rdata(arr_q)
  );

  // address stage, then output stage
  always_ff @(posedge clk) begin
    rd_addr_q <= eff_addr;
    if (rst) begin
      rd_vld_q <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      rd_vld_q <= rd_go;
      drv_q    <= rd_vld_q && !sleep;
    end
  end

  assign rdata_drv = drv_q && !out_en_n && !sleep;
  assign rdata     = rdata_drv ? arr_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe_ctl_n,
  input logic             strobe_proc_n,
  input logic             sel_a_n,
  input logic             sel_b_n,
  input logic             sel_c,
  input logic             wr_all_n,
  input logic             out_en_n,
  input logic             sleep,
  input logic             rdata_drv
);
  logic sel_ok;
  logic strobed;
  assign sel_ok  = !sel_a_n && !sel_b_n && sel_c;
  assign strobed = !strobe_ctl_n || !strobe_proc_n;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rdata_drv);

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (!sleep && sel_ok && !strobe_proc_n) ##1 !sleep ##1 (!sleep && !out_en_n)
      |-> rdata_drv);

  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strobed && !sel_ok) |=> ##1 !rdata_drv);

  p_oe_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rdata_drv);

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!sleep && sel_ok && !strobe_ctl_n && strobe_proc_n && !wr_all_n)
      |=> ##1 !rdata_drv);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !rdata_drv);
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst),
  .strobe_ctl_n(strobe_ctl_n), .strobe_proc_n(strobe_proc_n),
  .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
  .wr_all_n(wr_all_n), .out_en_n(out_en_n), .sleep(sleep),
  .rdata_drv(rdata_drv)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          strobe_ctl_n = 1'b1, strobe_proc_n = 1'b1, burst_step_n = 1'b1;
  logic          sel_a_n = 1'b0, sel_b_n = 1'b0, sel_c = 1'b1;
  logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [DW-1:0] wdata = '0;
  logic          out_en_n = 1'b0, sleep = 1'b0, seq_linear = 1'b1;
  logic [DW-1:0] rdata;
  logic          rdata_drv;

  always #10 clk = ~clk;

  burst_sram dut_i (
    .clk(clk), .rst(rst), .addr(addr),
    .strobe_ctl_n(strobe_ctl_n), .strobe_proc_n(strobe_proc_n),
    .burst_step_n(burst_step_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep), .seq_linear(seq_linear),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected-behaviour state
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_active;
  logic [AW-1:0] m_base;
  int            m_beat;
  bit            m_rdv;
  logic [AW-1:0] m_rda;
  bit            m_drv;
  logic [DW-1:0] m_q;

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, int k, bit lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + k) : (b[1:0] ^ 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [3:0] lanes_of(bit ga, bit bq, logic [3:0] ln);
    if (!ga) return 4'hF;
    if (!bq) return ~ln;
    return 4'h0;
  endfunction

  task automatic model_edge();
    bit sel, stb, ld, cont, wok, rd;
    logic [3:0] we;
    logic [AW-1:0] ea;
    m_q   = m_mem[m_rda];
    m_drv = m_rdv && !sleep && !rst;
    sel = !sel_a_n && !sel_b_n && sel_c;
    stb = !strobe_ctl_n || !strobe_proc_n;
    ld = 0; cont = 0;
    if (!rst && !sleep) begin
      if (stb) ld = sel;
      else     cont = m_active;
    end
    if (ld) ea = addr;
    else if (cont && !burst_step_n) ea = burst_addr(m_base, m_beat + 1, seq_linear);
    else ea = burst_addr(m_base, m_beat, seq_linear);
    wok = cont || (ld && strobe_proc_n);
    we  = wok ? lanes_of(wr_all_n, wr_byte_n, lane_wr_n) : 4'h0;
    for (int i = 0; i < 4; i++)
      if (we[i]) m_mem[ea][i*8 +: 8] = wdata[i*8 +: 8];
    rd = (ld || cont) && (we == 4'h0);
    m_rda = ea;
    m_rdv = rst ? 1'b0 : rd;
    if (rst || sleep) m_active = 0;
    else if (stb) m_active = sel;
    if (rst) begin m_base = '0; m_beat = 0; end
    else if (ld) begin m_base = addr; m_beat = 0; end
    else if (cont && !burst_step_n) m_beat = (m_beat + 1) % 4;
  endtask

  task automatic check_out(string tag);
    bit edrv;
    logic [DW-1:0] ed;
    edrv = m_drv && !out_en_n && !sleep;
    ed   = edrv ? m_q : '0;
    n_chk++;
    if (rdata_drv !== edrv || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h",
               tag, rdata_drv, rdata, edrv, ed);
    end
  endtask

  // one clock: settle inputs, check outputs, then let the edge happen
  task automatic tick(string tag);
    #1 check_out(tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    strobe_ctl_n = 1; strobe_proc_n = 1; burst_step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF;
    sel_a_n = 0; sel_b_n = 0; sel_c = 1; out_en_n = 0; sleep = 0;
  endtask

  task automatic wr_word(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    idle_in(); addr = a; strobe_ctl_n = 0; wr_all_n = 0; wdata = d;
    tick(tag);
  endtask

  task automatic rd_load(logic [AW-1:0] a, bit proc, string tag);
    idle_in(); addr = a;
    if (proc) strobe_proc_n = 0; else strobe_ctl_n = 0;
    tick(tag);
  endtask

  task automatic nops(int n, string tag);
    for (int i = 0; i < n; i++) begin idle_in(); tick(tag); end
  endtask

  initial begin
    void'($urandom(32'd5150));
    m_active = 0; m_base = '0; m_beat = 0; m_rdv = 0; m_rda = '0; m_drv = 0; m_q = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    @(negedge clk);
    // R1: reset state
    rst = 1; idle_in(); tick("R1"); tick("R1");
    rst = 0; tick("R1"); nops(2, "R1");

    // fill the array (R3 global writes)
    for (int i = 0; i < DEPTH; i++) wr_word(AW'(i), {8'(i), 8'(~i), 8'(i*3), 8'hA5}, "R3");
    nops(2, "R10");

    // R2: pipelined read from each strobe
    rd_load(6'd5, 1, "R2"); nops(3, "R2");
    rd_load(6'd9, 0, "R2"); nops(3, "R2");

    // R3: global write overrides lane controls
    idle_in(); addr = 6'd10; strobe_ctl_n = 0; wr_all_n = 0; wr_byte_n = 1;
    lane_wr_n = 4'hF; wdata = 32'hDEADBEEF; tick("R3");
    rd_load(6'd10, 1, "R3"); nops(3, "R3");

    // R4: byte writes, single, pair, none, qualifier off
    idle_in(); addr = 6'd11; strobe_ctl_n = 0; wr_byte_n = 0; lane_wr_n = 4'b1110;
    wdata = 32'h11223344; tick("R4");
    wr_byte_n = 0; lane_wr_n = 4'b0101; strobe_ctl_n = 1; wdata = 32'h55667788; tick("R4");
    rd_load(6'd11, 1, "R4"); nops(3, "R4");
    idle_in(); addr = 6'd12; strobe_ctl_n = 0; wr_byte_n = 0; lane_wr_n = 4'hF;
    wdata = 32'hFFFFFFFF; tick("R4"); nops(3, "R4");
    idle_in(); addr = 6'd13; strobe_ctl_n = 0; wr_byte_n = 1; lane_wr_n = 4'h0;
    wdata = 32'hFFFFFFFF; tick("R4"); nops(3, "R4");

    // R5: processor strobe load ignores write inputs
    idle_in(); addr = 6'd14; strobe_proc_n = 0; wr_all_n = 0; wdata = 32'h0BADF00D;
    tick("R5"); nops(2, "R5");
    rd_load(6'd14, 0, "R5"); nops(3, "R5");

    // R6: bursts from every offset, both orders, with wrap
    for (int lin = 0; lin < 2; lin++)
      for (int b = 0; b < 4; b++) begin
        seq_linear = lin[0];
        rd_load(AW'(20 + b), 1, "R6");
        for (int k = 0; k < 5; k++) begin idle_in(); burst_step_n = 0; tick("R6"); end
        nops(2, "R6");
      end
    seq_linear = 1;

    // R7: suspended steps
    rd_load(6'd33, 1, "R7");
    idle_in(); burst_step_n = 0; tick("R7");
    idle_in(); tick("R7"); idle_in(); tick("R7");
    idle_in(); burst_step_n = 0; tick("R7"); nops(3, "R7");

    // R8: deselect through each select, continues ignored afterwards
    rd_load(6'd40, 1, "R8");
    idle_in(); strobe_ctl_n = 0; sel_a_n = 1; tick("R8");
    idle_in(); burst_step_n = 0; wr_all_n = 0; wdata = 32'h12345678; tick("R8");
    nops(2, "R8");
    rd_load(6'd40, 1, "R8");
    idle_in(); strobe_proc_n = 0; sel_c = 0; tick("R8");
    idle_in(); strobe_ctl_n = 0; sel_b_n = 1; tick("R8"); nops(3, "R8");

    // R9: output enable gates asynchronously
    rd_load(6'd41, 1, "R9");
    idle_in(); out_en_n = 1; tick("R9");
    idle_in(); #5 out_en_n = 1; tick("R9");
    nops(3, "R9");

    // R12 / R10: write then read next cycle
    wr_word(6'd42, 32'hCAFE0042, "R10");
    rd_load(6'd42, 1, "R12"); nops(3, "R12");

    // R11: sleep ignores inputs and leaves the block deselected
    rd_load(6'd43, 1, "R11");
    idle_in(); sleep = 1; tick("R11");
    idle_in(); sleep = 1; strobe_ctl_n = 0; addr = 6'd43; wr_all_n = 0;
    wdata = 32'h0; tick("R11");
    idle_in(); burst_step_n = 0; tick("R11"); nops(2, "R11");
    rd_load(6'd43, 1, "R11"); nops(3, "R11");

    // random mix
    for (int c = 0; c < 3000; c++) begin
      int r;
      idle_in();
      r = $urandom_range(0, 99);
      addr = AW'($urandom);
      wdata = $urandom;
      strobe_ctl_n  = (r < 20) ? 1'b0 : 1'b1;
      strobe_proc_n = (r >= 15 && r < 30) ? 1'b0 : 1'b1;
      burst_step_n  = $urandom_range(0, 2) == 0;
      sel_a_n = ($urandom_range(0, 9) == 0);
      sel_b_n = ($urandom_range(0, 9) == 0);
      sel_c   = ($urandom_range(0, 9) != 0);
      wr_all_n  = ($urandom_range(0, 5) != 0);
      wr_byte_n = ($urandom_range(0, 2) != 0);
      lane_wr_n = 4'($urandom);
      out_en_n  = ($urandom_range(0, 7) == 0);
      sleep     = ($urandom_range(0, 39) == 0);
      seq_linear = ($urandom_range(0, 1) == 1);
      tick("R4");
    end
    nops(3, "R2");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule